// File: doc/BRIEF.md
# Per-Bit Attribute Register Bank

This block is a small bank of 32-bit control and status words. Every bit position in every word has its own access behaviour, fixed at elaboration by a set of parameter masks with one mask per behaviour. The host side is a simple strobed port: address, read strobe, write strobe, write data, byte enables and combinational read data. The hardware side provides per-bit event-set lines, live status lines, an initialization load port for strap-style or serial-memory-style preloading, a signal that marks the end of that load, and a global unlock input.

Each bit carries out the read and write side effects of its behaviour. The kinds are plain read/write, constant or live read-only, clear-on-read (with or without host write), write-one-to-clear event flags, writable only while unlocked, write-transient qualifiers that gate the other writable bits of their word, initialize-once, and always-zero. Bits that no mask claims are reserved. The bank knows nothing about what individual fields mean. A protocol adapter in front of it turns bus traffic into the strobes.

Top module: `regbank_attr`

## Requirements
- R1: A read/write bit takes host write data for each byte whose enable is set, and keeps its value for bytes whose enable is clear. It resets to its reset value. Default layout: word 0 bits 7:0 with reset value 0x5A, and word 2 bits 15:0 with reset value 0.
- R2: A read-only bit ignores host writes. A constant bit returns its parameter value; by default word 0 bits 27:24 read 0xA. A live bit returns the current status input; by default word 0 bits 31:28 show hw_status[31:28] and word 3 bits 15:0 show hw_status[111:96].
- R3: A clear-on-read bit (default word 1 bits 15:8) returns its value during the read strobe and reads zero from the next cycle on. Host writes do not change it. A hardware set in the same cycle as the clearing read leaves the bit at one.
- R4: A clear-on-read-and-write bit (default word 1 bits 23:16) is cleared by a read and takes host write data on a write. A hardware set also sets it.
- R5: A write-one-to-clear bit (default word 1 bits 7:0 and word 2 bits 23:16) is set only by hw_set. Writing one clears it, writing zero leaves it unchanged, and hardware never clears it. A set and a clearing write in the same cycle leave it at one.
- R6: A lock-gated bit (default word 0 bits 15:8 and word 3 bits 31:16) takes host writes only while unlock is high. While unlock is low, writes to it are dropped.
- R7: A write-transient bit (default word 2 bit 31) always reads zero. In a word that holds such bits, the read/write, lock-gated, clear-on-read-and-write and write-one-to-clear bits change only when that same write puts a one, with its byte enabled, on at least one write-transient bit.
- R8: An initialize-once bit (default word 0 bits 23:16) loads only from init_data at init_addr while init_we is high, and only until init_done has been seen. A load in the same cycle as init_done is still taken. Host writes never change it, and after init_done only reset does.
- R9: Reserved bits (default word 1 bits 31:24 and word 2 bits 30:24) read zero and ignore writes. An address at or above the word count reads zero and has no side effect.
- R10: host_rdata is zero in any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Word address of the host access |
| host_rd | input | 1 | Read strobe; applies clear-on-read side effects |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data |
| host_be | input | 4 | Byte enables for the write |
| host_rdata | output | 32 | Read data, valid in the strobe cycle |
| hw_set | input | NUM_REGS*32 | Per-bit event set lines |
| hw_status | input | NUM_REGS*32 | Per-bit live status values |
| init_we | input | 1 | Initialization load strobe |
| init_addr | input | ADDR_W | Word address of the initialization load |
| init_data | input | 32 | Initialization load data |
| init_done | input | 1 | Marks the end of initialization (sticky inside) |
| unlock | input | 1 | Global unlock for lock-gated bits |

## Verification
Assertions check every cycle that clear-on-read bits are zero after an in-range read unless a set arrived, and that event flags rise on a set and never fall without a host write. They also check that lock-gated bits hold while locked, that initialize-once bits hold after init_done, and that reserved, write-transient and out-of-range reads are zero. The bench scenarios cover what a single-cycle property cannot express. These include byte-lane masking of writes, the gating of a whole word by its qualifier bit, set-versus-clear collisions, the preload being taken before init_done and ignored after it, and stray writes to unmapped addresses leaving the bank untouched.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int WORD_W = 32;
    localparam int LANE_W = 8;
    localparam int BE_W   = WORD_W / LANE_W;

    typedef enum logic [3:0] {
        ATTR_RSVD,
        ATTR_RW,
        ATTR_RO_CONST,
        ATTR_RO_LIVE,
        ATTR_RC,
        ATTR_RCW,
        ATTR_W1C,
        ATTR_RWL,
        ATTR_WT,
        ATTR_HWINIT
    } bit_attr_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [BE_W-1:0]   be;
        logic [WORD_W-1:0] data;
    } host_acc_s;

    // Expand byte enables to a per-bit mask.
    function automatic logic [WORD_W-1:0] lane_mask(input logic [BE_W-1:0] be);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < BE_W; i++) begin
            m[i*LANE_W +: LANE_W] = {LANE_W{be[i]}};
        end
        return m;
    endfunction

    // Resolve one bit's behaviour from the mask bits; the first match wins.
    function automatic bit_attr_e pick_attr(
        input logic wt,  input logic cst, input logic live,
        input logic hwi, input logic rwl, input logic w1c,
        input logic rcw, input logic rc,  input logic rw);
        if (wt)        return ATTR_WT;
        else if (cst)  return ATTR_RO_CONST;
        else if (live) return ATTR_RO_LIVE;
        else if (hwi)  return ATTR_HWINIT;
        else if (rwl)  return ATTR_RWL;
        else if (w1c)  return ATTR_W1C;
        else if (rcw)  return ATTR_RCW;
        else if (rc)   return ATTR_RC;
        else if (rw)   return ATTR_RW;
        else           return ATTR_RSVD;
    endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 3
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                stb,
    output logic [NUM_REGS-1:0] sel
);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
        assign sel[r] = stb && (addr == ADDR_W'(r));
    end

endmodule

// File: rtl/regbank_word.sv
module regbank_word
    import regbank_pkg::*;
#(
    parameter logic [WORD_W-1:0] RW_M   = '0,
    parameter logic [WORD_W-1:0] RWL_M  = '0,
    parameter logic [WORD_W-1:0] RC_M   = '0,
    parameter logic [WORD_W-1:0] RCW_M  = '0,
    parameter logic [WORD_W-1:0] W1C_M  = '0,
    parameter logic [WORD_W-1:0] WT_M   = '0,
    parameter logic [WORD_W-1:0] HWI_M  = '0,
    parameter logic [WORD_W-1:0] CST_M  = '0,
    parameter logic [WORD_W-1:0] LIVE_M = '0,
    parameter logic [WORD_W-1:0] CST_V  = '0,
    parameter logic [WORD_W-1:0] RST_V  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  host_acc_s         acc,
    input  logic              unlock,
    input  logic              init_ld,
    input  logic [WORD_W-1:0] init_data,
    input  logic [WORD_W-1:0] hw_set,
    input  logic [WORD_W-1:0] hw_status,
    output logic [WORD_W-1:0] value
);

    localparam bit HAS_WT = |WT_M;

    logic [WORD_W-1:0] lanes;
    logic              wt_ok;
    logic [WORD_W-1:0] wr_bits;

    // Qualification is decided once per write for the whole word.
    assign lanes   = lane_mask(acc.be);
    assign wt_ok   = HAS_WT ? |(acc.data & WT_M & lanes) : 1'b1;
    assign wr_bits = {WORD_W{acc.wr & wt_ok}} & lanes;

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        localparam bit_attr_e KIND = pick_attr(WT_M[i], CST_M[i], LIVE_M[i], HWI_M[i],
                                               RWL_M[i], W1C_M[i], RCW_M[i], RC_M[i], RW_M[i]);
        case (KIND)
            ATTR_RW: begin : g_rw
                logic q;
                always_ff @(posedge clk) begin
                    if (rst)             q <= RST_V[i];
                    else if (wr_bits[i]) q <= acc.data[i];
                end
                assign value[i] = q;
            end
            ATTR_RWL: begin : g_rwl
                logic q;
                always_ff @(posedge clk) begin
                    if (rst)                      q <= RST_V[i];
                    else if (wr_bits[i] && unlock) q <= acc.data[i];
                end
                assign value[i] = q;
            end
            ATTR_RC: begin : g_rc
                logic q;
                always_ff @(posedge clk) begin
                    if (rst)            q <= RST_V[i];
                    else if (hw_set[i]) q <= 1'b1;
                    else if (acc.rd)    q <= 1'b0;
                end
                assign value[i] = q;
            end
            ATTR_RCW: begin : g_rcw
                logic q;
                always_ff @(posedge clk) begin
                    if (rst)             q <= RST_V[i];
                    else if (hw_set[i])  q <= 1'b1;
                    else if (wr_bits[i]) q <= acc.data[i];
                    else if (acc.rd)     q <= 1'b0;
                end
                assign value[i] = q;
            end
            ATTR_W1C: begin : g_w1c
                logic q;
                always_ff @(posedge clk) begin
                    if (rst)                             q <= RST_V[i];
                    else if (hw_set[i])                  q <= 1'b1;
                    else if (wr_bits[i] && acc.data[i])  q <= 1'b0;
                end
                assign value[i] = q;
            end
            ATTR_HWINIT: begin : g_hwi
                logic q;
                always_ff @(posedge clk) begin
                    if (rst)          q <= RST_V[i];
                    else if (init_ld) q <= init_data[i];
                end
                assign value[i] = q;
            end
            ATTR_RO_CONST: begin : g_cst
                assign value[i] = CST_V[i];
            end
            ATTR_RO_LIVE: begin : g_live
                assign value[i] = hw_status[i];
            end
            default: begin : g_zero
                assign value[i] = 1'b0;
            end
        endcase
    end

    logic unused_word;
    assign unused_word = ^{acc, unlock, init_ld, init_data, hw_set, hw_status, wr_bits};

endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic [NUM_REGS-1:0][WORD_W-1:0] words,
    input  logic [NUM_REGS-1:0]             sel,
    output logic [WORD_W-1:0]               rdata
);

    always_comb begin
        rdata = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            rdata = rdata | (words[r] & {WORD_W{sel[r]}});
        end
    end

endmodule

// File: rtl/regbank_attr.sv
module regbank_attr
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 3,
    parameter logic [NUM_REGS*WORD_W-1:0] RW_MASK    = 128'h00000000_0000FFFF_00000000_000000FF,
    parameter logic [NUM_REGS*WORD_W-1:0] RWL_MASK   = 128'hFFFF0000_00000000_00000000_0000FF00,
    parameter logic [NUM_REGS*WORD_W-1:0] RC_MASK    = 128'h00000000_00000000_0000FF00_00000000,
    parameter logic [NUM_REGS*WORD_W-1:0] RCW_MASK   = 128'h00000000_00000000_00FF0000_00000000,
    parameter logic [NUM_REGS*WORD_W-1:0] W1C_MASK   = 128'h00000000_00FF0000_000000FF_00000000,
    parameter logic [NUM_REGS*WORD_W-1:0] WT_MASK    = 128'h00000000_80000000_00000000_00000000,
    parameter logic [NUM_REGS*WORD_W-1:0] HWI_MASK   = 128'h00000000_00000000_00000000_00FF0000,
    parameter logic [NUM_REGS*WORD_W-1:0] CONST_MASK = 128'h00000000_00000000_00000000_0F000000,
    parameter logic [NUM_REGS*WORD_W-1:0] LIVE_MASK  = 128'h0000FFFF_00000000_00000000_F0000000,
    parameter logic [NUM_REGS*WORD_W-1:0] CONST_VAL  = 128'h00000000_00000000_00000000_0A000000,
    parameter logic [NUM_REGS*WORD_W-1:0] RST_VAL    = 128'h00000000_00000000_00000000_0000005A
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic                       host_rd,
    input  logic                       host_wr,
    input  logic [WORD_W-1:0]          host_wdata,
    input  logic [BE_W-1:0]            host_be,
    output logic [WORD_W-1:0]          host_rdata,
    input  logic [NUM_REGS*WORD_W-1:0] hw_set,
    input  logic [NUM_REGS*WORD_W-1:0] hw_status,
    input  logic                       init_we,
    input  logic [ADDR_W-1:0]          init_addr,
    input  logic [WORD_W-1:0]          init_data,
    input  logic                       init_done,
    input  logic                       unlock
);

    localparam int BANK_W = NUM_REGS * WORD_W;

    logic [NUM_REGS-1:0]             rd_sel;
    logic [NUM_REGS-1:0]             wr_sel;
    logic [NUM_REGS-1:0]             ld_sel;
    logic [NUM_REGS-1:0][WORD_W-1:0] words;
    logic [BANK_W-1:0]               bank_view;
    logic                            done_q;

    regbank_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_rd_dec (
        .addr(host_addr), .stb(host_rd), .sel(rd_sel));
    regbank_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_wr_dec (
        .addr(host_addr), .stb(host_wr), .sel(wr_sel));
    regbank_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_ld_dec (
        .addr(init_addr), .stb(init_we), .sel(ld_sel));

    // Initialization window closes for good once init_done is seen.
    always_ff @(posedge clk) begin
        if (rst)            done_q <= 1'b0;
        else if (init_done) done_q <= 1'b1;
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
        host_acc_s acc;
        assign acc = '{rd: rd_sel[r], wr: wr_sel[r], be: host_be, data: host_wdata};

        regbank_word #(
            .RW_M  (RW_MASK   [r*WORD_W +: WORD_W]),
            .RWL_M (RWL_MASK  [r*WORD_W +: WORD_W]),
            .RC_M  (RC_MASK   [r*WORD_W +: WORD_W]),
            .RCW_M (RCW_MASK  [r*WORD_W +: WORD_W]),
            .W1C_M (W1C_MASK  [r*WORD_W +: WORD_W]),
            .WT_M  (WT_MASK   [r*WORD_W +: WORD_W]),
            .HWI_M (HWI_MASK  [r*WORD_W +: WORD_W]),
            .CST_M (CONST_MASK[r*WORD_W +: WORD_W]),
            .LIVE_M(LIVE_MASK [r*WORD_W +: WORD_W]),
            .CST_V (CONST_VAL [r*WORD_W +: WORD_W]),
            .RST_V (RST_VAL   [r*WORD_W +: WORD_W])
        ) u_word (
            .clk      (clk),
            .rst      (rst),
            .acc      (acc),
            .unlock   (unlock),
            .init_ld  (ld_sel[r] & ~done_q),
            .init_data(init_data),
            .hw_set   (hw_set   [r*WORD_W +: WORD_W]),
            .hw_status(hw_status[r*WORD_W +: WORD_W]),
            .value    (words[r])
        );
    end

    assign bank_view = words;

    regbank_rdmux #(.NUM_REGS(NUM_REGS)) u_rdmux (
        .words(words), .sel(rd_sel), .rdata(host_rdata));

    logic unused_top;
    assign unused_top = ^bank_view;

endmodule

// File: rtl/regbank_attr_chk.sv
module regbank_attr_chk #(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 3,
    parameter logic [NUM_REGS*32-1:0] RC_MASK   = '0,
    parameter logic [NUM_REGS*32-1:0] W1C_MASK  = '0,
    parameter logic [NUM_REGS*32-1:0] RWL_MASK  = '0,
    parameter logic [NUM_REGS*32-1:0] HWI_MASK  = '0,
    parameter logic [NUM_REGS*32-1:0] WT_MASK   = '0,
    parameter logic [NUM_REGS*32-1:0] IMPL_MASK = '0
) (
    input logic                   clk,
    input logic                   rst,
    input logic [ADDR_W-1:0]      host_addr,
    input logic                   host_rd,
    input logic                   host_wr,
    input logic [31:0]            host_rdata,
    input logic [NUM_REGS*32-1:0] hw_set,
    input logic                   unlock,
    input logic                   init_done,
    input logic [NUM_REGS*32-1:0] bank_view
);

    logic                   in_range;
    logic [NUM_REGS*32-1:0] addr_sel;
    logic [31:0]            impl_word;
    logic [31:0]            wt_word;
    logic                   done_seen;

    assign in_range = int'(host_addr) < NUM_REGS;

    always_comb begin
        addr_sel  = '0;
        impl_word = '0;
        wt_word   = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (int'(host_addr) == r) begin
                addr_sel[r*32 +: 32] = '1;
                impl_word = IMPL_MASK[r*32 +: 32];
                wt_word   = WT_MASK[r*32 +: 32];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            done_seen <= 1'b0;
        else if (init_done) done_seen <= 1'b1;
    end

    // R3
    rc_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && in_range) |=>
            ((bank_view & RC_MASK & $past(addr_sel) & ~$past(hw_set)) == '0));

    // R5
    w1c_set_chk: assert property (@(posedge clk) disable iff (rst)
        ((hw_set & W1C_MASK) != '0) |=>
            ((bank_view & $past(hw_set & W1C_MASK)) == $past(hw_set & W1C_MASK)));

    // R5
    w1c_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !host_wr |=> ((~bank_view & $past(bank_view) & W1C_MASK) == '0));

    // R6
    rwl_locked_chk: assert property (@(posedge clk) disable iff (rst)
        !unlock |=> ((bank_view & RWL_MASK) == $past(bank_view & RWL_MASK)));

    // R8
    hwinit_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        done_seen |=> $stable(bank_view & HWI_MASK));

    // R7
    wt_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && in_range) |-> ((host_rdata & wt_word) == '0));

    // R9
    rsvd_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && in_range) |-> ((host_rdata & ~impl_word) == '0));

    // R9
    oob_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !in_range) |-> (host_rdata == '0));

endmodule

bind regbank_attr regbank_attr_chk #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .RC_MASK  (RC_MASK),
    .W1C_MASK (W1C_MASK),
    .RWL_MASK (RWL_MASK),
    .HWI_MASK (HWI_MASK),
    .WT_MASK  (WT_MASK),
    .IMPL_MASK(RW_MASK | RWL_MASK | RC_MASK | RCW_MASK | W1C_MASK | HWI_MASK | CONST_MASK | LIVE_MASK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_addr (host_addr),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .host_rdata(host_rdata),
    .hw_set    (hw_set),
    .unlock    (unlock),
    .init_done (init_done),
    .bank_view (bank_view)
);

// File: tb/regbank_attr_test.sv
`timescale 1ns/1ps
module regbank_attr_test;

    localparam int NREG = 4;
    localparam int AW   = 3;
    localparam logic [127:0] M_RW   = 128'h00000000_0000FFFF_00000000_000000FF;
    localparam logic [127:0] M_RWL  = 128'hFFFF0000_00000000_00000000_0000FF00;
    localparam logic [127:0] M_RC   = 128'h00000000_00000000_0000FF00_00000000;
    localparam logic [127:0] M_RCW  = 128'h00000000_00000000_00FF0000_00000000;
    localparam logic [127:0] M_W1C  = 128'h00000000_00FF0000_000000FF_00000000;
    localparam logic [127:0] M_WT   = 128'h00000000_80000000_00000000_00000000;
    localparam logic [127:0] M_HWI  = 128'h00000000_00000000_00000000_00FF0000;
    localparam logic [127:0] M_CST  = 128'h00000000_00000000_00000000_0F000000;
    localparam logic [127:0] M_LIVE = 128'h0000FFFF_00000000_00000000_F0000000;
    localparam logic [127:0] V_CST  = 128'h00000000_00000000_00000000_0A000000;
    localparam logic [127:0] V_RST  = 128'h00000000_00000000_00000000_0000005A;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] host_addr = '0;
    logic          host_rd = 1'b0;
    logic          host_wr = 1'b0;
    logic [31:0]   host_wdata = '0;
    logic [3:0]    host_be = '0;
    logic [31:0]   host_rdata;
    logic [127:0]  hw_set = '0;
    logic [127:0]  hw_status = '0;
    logic          init_we = 1'b0;
    logic [AW-1:0] init_addr = '0;
    logic [31:0]   init_data = '0;
    logic          init_done = 1'b0;
    logic          unlock = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [127:0] m_q;
    logic         m_done;

    always #5 clk = ~clk;

    regbank_attr #(
        .NUM_REGS(NREG), .ADDR_W(AW),
        .RW_MASK(M_RW), .RWL_MASK(M_RWL), .RC_MASK(M_RC), .RCW_MASK(M_RCW),
        .W1C_MASK(M_W1C), .WT_MASK(M_WT), .HWI_MASK(M_HWI), .CONST_MASK(M_CST),
        .LIVE_MASK(M_LIVE), .CONST_VAL(V_CST), .RST_VAL(V_RST)
    ) uut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_be(host_be),
        .host_rdata(host_rdata), .hw_set(hw_set), .hw_status(hw_status),
        .init_we(init_we), .init_addr(init_addr), .init_data(init_data),
        .init_done(init_done), .unlock(unlock)
    );

    // Behaviour codes: 1 rw, 2 const, 3 live, 4 rc, 5 rcw, 6 w1c, 7 lock, 8 wt, 9 init, 0 zero
    function automatic int kind_of(input int idx);
        if (M_WT[idx])        return 8;
        else if (M_CST[idx])  return 2;
        else if (M_LIVE[idx]) return 3;
        else if (M_HWI[idx])  return 9;
        else if (M_RWL[idx])  return 7;
        else if (M_W1C[idx])  return 6;
        else if (M_RCW[idx])  return 5;
        else if (M_RC[idx])   return 4;
        else if (M_RW[idx])   return 1;
        return 0;
    endfunction

    function automatic logic [31:0] model_read();
        logic [31:0] v = '0;
        int a = int'(host_addr);
        if (!host_rd || a >= NREG) return '0;
        for (int b = 0; b < 32; b++) begin
            int idx = a * 32 + b;
            case (kind_of(idx))
                2:             v[b] = V_CST[idx];
                3:             v[b] = hw_status[idx];
                1, 4, 5, 6, 7, 9: v[b] = m_q[idx];
                default:       v[b] = 1'b0;
            endcase
        end
        return v;
    endfunction

    function automatic logic [127:0] model_next();
        logic [127:0] n = m_q;
        for (int a = 0; a < NREG; a++) begin
            bit wsel = host_wr && (int'(host_addr) == a);
            bit rsel = host_rd && (int'(host_addr) == a);
            bit lsel = init_we && (int'(init_addr) == a) && !m_done;
            logic [31:0] wtw = M_WT[a*32 +: 32];
            logic [31:0] lanes;
            bit ok;
            for (int k = 0; k < 4; k++) lanes[k*8 +: 8] = {8{host_be[k]}};
            ok = (wtw == '0) || ((host_wdata & wtw & lanes) != '0);
            for (int b = 0; b < 32; b++) begin
                int idx = a * 32 + b;
                bit en = wsel && ok && host_be[b/8];
                bit d  = host_wdata[b];
                case (kind_of(idx))
                    1: if (en) n[idx] = d;
                    7: if (en && unlock) n[idx] = d;
                    4: if (hw_set[idx]) n[idx] = 1'b1; else if (rsel) n[idx] = 1'b0;
                    5: if (hw_set[idx]) n[idx] = 1'b1; else if (en) n[idx] = d;
                       else if (rsel) n[idx] = 1'b0;
                    6: if (hw_set[idx]) n[idx] = 1'b1; else if (en && d) n[idx] = 1'b0;
                    9: if (lsel) n[idx] = init_data[b];
                    default: ;
                endcase
            end
        end
        return n;
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R1";
            1: return "R5";
            2: return "R7";
            3: return "R6";
            default: return host_rd ? "R9" : "R10";
        endcase
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: addr=%0d rdata=%h expected=%h at %0t", tag, host_addr, got, exp, $time);
        end
    endtask

    // One clock: compare against the model, then advance the model at the edge.
    task automatic cycle();
        logic [127:0] nx;
        logic         nd;
        #1;
        check(host_rdata, model_read(), host_rd ? tag_of(int'(host_addr)) : "R10");
        nx = model_next();
        nd = m_done | init_done;
        @(posedge clk);
        m_q    = nx;
        m_done = nd;
        @(negedge clk);
    endtask

    task automatic rd_expect(input int a, input logic [31:0] exp, input string tag);
        host_addr = AW'(a);
        host_rd   = 1'b1;
        #1;
        check(host_rdata, exp, tag);
        cycle();
        host_rd = 1'b0;
    endtask

    task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
        host_addr  = AW'(a);
        host_wdata = d;
        host_be    = be;
        host_wr    = 1'b1;
        cycle();
        host_wr = 1'b0;
    endtask

    task automatic pulse_set(input int idx);
        hw_set[idx] = 1'b1;
        cycle();
        hw_set[idx] = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_q    = V_RST;
        m_done = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: idle port reads zero
        host_addr = '0;
        #1; check(host_rdata, 32'h0, "R10");
        cycle();

        // R1 R2: reset state of word 0
        rd_expect(0, 32'h0A00005A, "R1");

        // R1: byte-lane write
        wr(0, 32'hFFFFFFFF, 4'b0001);
        rd_expect(0, 32'h0A0000FF, "R1");

        // R6: locked write dropped, unlocked write taken
        wr(0, 32'h00003C00, 4'b0010);
        rd_expect(0, 32'h0A0000FF, "R6");
        unlock = 1'b1;
        wr(0, 32'h00003C00, 4'b0010);
        unlock = 1'b0;
        rd_expect(0, 32'h0A003CFF, "R6");

        // R2: live status and write to read-only lane
        hw_status[31:28] = 4'h9;
        rd_expect(0, 32'h9A003CFF, "R2");
        wr(0, 32'h00000000, 4'b1000);
        rd_expect(0, 32'h9A003CFF, "R2");

        // R8: preload, host write ignored, locked after init_done
        init_we = 1'b1; init_addr = '0; init_data = 32'hFFC3FFFF;
        cycle();
        init_we = 1'b0;
        rd_expect(0, 32'h9AC33CFF, "R8");
        unlock = 1'b1;
        wr(0, 32'h00000000, 4'b0100);
        unlock = 1'b0;
        rd_expect(0, 32'h9AC33CFF, "R8");
        init_done = 1'b1;
        cycle();
        init_done = 1'b0;
        init_we = 1'b1; init_data = 32'h00110000;
        cycle();
        init_we = 1'b0;
        rd_expect(0, 32'h9AC33CFF, "R8");

        // R3 R4 R5: events in word 1
        hw_set[32] = 1'b1; hw_set[40] = 1'b1; hw_set[48] = 1'b1;
        cycle();
        hw_set = '0;
        rd_expect(1, 32'h00010101, "R3");
        rd_expect(1, 32'h00000001, "R4");
        wr(1, 32'h00FFFF00, 4'b1111);
        rd_expect(1, 32'h00FF0001, "R4");
        rd_expect(1, 32'h00000001, "R4");
        wr(1, 32'h00000001, 4'b1111);
        rd_expect(1, 32'h00000000, "R5");
        hw_set[33] = 1'b1;
        wr(1, 32'h00000002, 4'b1111);
        hw_set = '0;
        rd_expect(1, 32'h00000002, "R5");

        // R3: set arriving with the clearing read survives
        pulse_set(41);
        hw_set[41] = 1'b1;
        rd_expect(1, 32'h00000202, "R3");
        hw_set = '0;
        rd_expect(1, 32'h00000202, "R3");
        rd_expect(1, 32'h00000002, "R3");

        // R9: reserved lane of word 1
        wr(1, 32'hFF000000, 4'b1000);
        rd_expect(1, 32'h00000002, "R9");

        // R7: qualifier bit in word 2
        wr(2, 32'h00001234, 4'b1111);
        rd_expect(2, 32'h00000000, "R7");
        wr(2, 32'h80001234, 4'b1111);
        rd_expect(2, 32'h00001234, "R7");
        pulse_set(80);
        rd_expect(2, 32'h00011234, "R5");
        wr(2, 32'h00010000, 4'b1111);
        rd_expect(2, 32'h00011234, "R7");
        wr(2, 32'h80010000, 4'b1100);
        rd_expect(2, 32'h00001234, "R7");
        wr(2, 32'h80005678, 4'b0011);
        rd_expect(2, 32'h00001234, "R7");

        // R9: out-of-range addresses
        rd_expect(5, 32'h0, "R9");
        rd_expect(4, 32'h0, "R9");
        unlock = 1'b1;
        wr(5, 32'hFFFFFFFF, 4'b1111);
        unlock = 1'b0;
        rd_expect(0, 32'h9AC33CFF, "R9");

        // R2 R6: word 3
        hw_status[111:96] = 16'hBEEF;
        unlock = 1'b1;
        wr(3, 32'h12340000, 4'b1111);
        unlock = 1'b0;
        rd_expect(3, 32'h1234BEEF, "R2");

        // Mixed traffic against the model
        for (int t = 0; t < 400; t++) begin
            host_rd    = ($urandom % 3) == 0;
            host_wr    = ($urandom % 3) == 0;
            host_addr  = AW'($urandom % 6);
            host_wdata = $urandom;
            host_be    = 4'($urandom);
            unlock     = $urandom % 2;
            for (int w = 0; w < 4; w++) begin
                hw_set[w*32 +: 32]    = $urandom & $urandom & $urandom;
                hw_status[w*32 +: 32] = $urandom;
            end
            init_we   = ($urandom % 8) == 0;
            init_addr = AW'($urandom % 4);
            init_data = $urandom;
            cycle();
        end
        host_rd = 1'b0; host_wr = 1'b0; hw_set = '0; init_we = 1'b0;
        cycle();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule